// File: doc/BRIEF.md
# Programmable 3x3 Color Conversion Matrix

This block converts a stream of three-component pixels (10 bits per component, red/green/blue order on input) from one color space to another, typically RGB to limited-range YCbCr for an overlay plane. Each component first receives a signed pre-offset. The three offset components are multiplied by a 3x3 matrix of signed fixed-point coefficients. The products are summed at full precision, rounded to the nearest integer, and receive a signed post-offset. Each result is then saturated to 10 bits.

Software programs the coefficients, offsets and an enable bit through a word-wide write port. Each 32-bit word carries two packed fields. Writes land in a pending copy of the settings. The pending copy moves into the working copy only when a frame-start strobe arrives, so no frame is converted with a half-updated matrix. With the enable bit clear, pixels pass through unchanged. The pipeline depth and the valid timing are the same in both modes.

Top module: `csc_matrix_top`

## Requirements
- R1: After reset, out_valid is low and the working settings are all zero with the enable clear, so pixels pass through unchanged until the first commit.
- R2: Every pixel appears at the outputs exactly two clock cycles after it is presented. out_valid repeats in_valid with the same two-cycle delay, including gaps, in both modes.
- R3: Bit 0 of the control word at address 0 enables conversion. When the committed bit is clear, each output component equals its input component exactly. The other bits of that word have no effect.
- R4: When enabled, output channel i equals ((sum over k of C[i][k]*(in_k + pre_k)) + 512) shifted arithmetically right by 10, plus post_i. Coefficients are 13-bit two's complement with 1.0 = 1024. The shift rounds toward minus infinity.
- R5: Each converted result is saturated: a negative value gives 0, and a value above 1023 gives 1023.
- R6: Coefficients are written at addresses 3 to 7, as pairs (00,01), (02,10), (11,12), (20,21), then (22) alone. The first entry of each pair is in bits [28:16] and the second is in bits [12:0]. Cij means row i (output channel), column j (input component).
- R7: Pre-offsets are written at address 1 (pre0 in [27:16], pre1 in [11:0]) and address 2 (pre2 in [11:0]). Post-offsets use the same layout at addresses 8 and 9. All offsets are 12-bit two's complement.
- R8: Register writes do not change the conversion until frame_start is pulsed. The strobe copies every pending field at once. A write in the same cycle as the strobe waits for the next strobe.
- R9: Writes to addresses 10 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| frame_start | input | 1 | Commits pending settings |
| in_valid | input | 1 | Input pixel valid |
| in_r | input | 10 | Input component 0 |
| in_g | input | 10 | Input component 1 |
| in_b | input | 10 | Input component 2 |
| out_valid | output | 1 | Output pixel valid |
| out_c0 | output | 10 | Output channel 0 (e.g. Y) |
| out_c1 | output | 10 | Output channel 1 (e.g. Cb) |
| out_c2 | output | 10 | Output channel 2 (e.g. Cr) |

## Verification
The bench sweeps a grid of input triples that includes 0 and 1023 through several committed settings. These are identity, RGB to limited-range YCbCr, full-scale and negative coefficients with extreme offsets, and single-unit coefficients. A design that shifted logically, truncated instead of adding 512, or wrapped instead of saturating would give outputs that are off by one or wrapped around. Fields placed in the wrong slot or pair would scramble the channels. The bench also streams pixels between writing new settings and strobing frame_start, which exposes a design that applies writes at once. Finally it writes junk to the unused addresses and to the upper control bits, and sends pixels with valid gaps, which catches a shortened pipeline or a valid that is not aligned with its data.

// File: rtl/csc_pkg.sv
package csc_pkg;
    parameter int PIX_W  = 10;
    parameter int COEF_W = 13;
    parameter int OFS_W  = 12;
    parameter int FRAC   = 10;
    parameter int NCH    = 3;
    parameter int CFG_AW = 4;
    parameter int CFG_DW = 32;
    parameter int HI_LSB = 16;

    localparam int A_W    = ((PIX_W + 1) > OFS_W ? (PIX_W + 1) : OFS_W) + 1;
    localparam int PROD_W = A_W + COEF_W;
    localparam int ACC_W  = PROD_W + $clog2(NCH) + 1;
    localparam int NCOEF  = NCH * NCH;
    localparam int NCW    = (NCOEF + 1) / 2;

    localparam logic signed [ACC_W-1:0] PIX_MAX_S = ACC_W'((1 << PIX_W) - 1);
    localparam logic signed [ACC_W-1:0] HALF_S    = ACC_W'(1 << (FRAC - 1));

    typedef logic [PIX_W-1:0] pix_t;
    typedef pix_t [NCH-1:0] pixel_t;

    typedef struct packed {
        logic                                 en;
        logic [NCH-1:0][NCH-1:0][COEF_W-1:0]  coef;
        logic [NCH-1:0][OFS_W-1:0]            pre;
        logic [NCH-1:0][OFS_W-1:0]            post;
    } csc_cfg_t;

    typedef enum logic [CFG_AW-1:0] {
        ADR_CTRL   = 4'd0,
        ADR_PRE01  = 4'd1,
        ADR_PRE2   = 4'd2,
        ADR_COEF0  = 4'd3,
        ADR_POST01 = 4'd8,
        ADR_POST2  = 4'd9
    } csc_addr_e;

    localparam logic [CFG_AW-1:0] ADR_LAST = 4'd9;

    function automatic logic signed [ACC_W-1:0] round_shift(input logic signed [ACC_W-1:0] v);
        logic signed [ACC_W-1:0] t;
        t = v + HALF_S;
        return t >>> FRAC;
    endfunction

    function automatic pix_t sat_pix(input logic signed [ACC_W-1:0] v);
        if (v < 0)
            return '0;
        else if (v > PIX_MAX_S)
            return '1;
        else
            return v[PIX_W-1:0];
    endfunction
endpackage

// File: rtl/csc_regs.sv
module csc_regs
    import csc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [CFG_AW-1:0] addr,
    input  logic [CFG_DW-1:0] wdata,
    input  logic              frame_start,
    output csc_cfg_t          active
);
    csc_cfg_t shadow;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
        end else if (we) begin
            case (addr)
                ADR_CTRL:   shadow.en <= wdata[0];
                ADR_PRE01: begin
                    shadow.pre[0] <= wdata[HI_LSB +: OFS_W];
                    shadow.pre[1] <= wdata[OFS_W-1:0];
                end
                ADR_PRE2:   shadow.pre[2] <= wdata[OFS_W-1:0];
                ADR_POST01: begin
                    shadow.post[0] <= wdata[HI_LSB +: OFS_W];
                    shadow.post[1] <= wdata[OFS_W-1:0];
                end
                ADR_POST2:  shadow.post[2] <= wdata[OFS_W-1:0];
                default: begin
                    for (int k = 0; k < NCW; k++) begin
                        if (addr == CFG_AW'(int'(ADR_COEF0) + k)) begin
                            shadow.coef[(2*k)/NCH][(2*k)%NCH] <= wdata[HI_LSB +: COEF_W];
                            if (2*k + 1 < NCOEF)
                                shadow.coef[(2*k+1)/NCH][(2*k+1)%NCH] <= wdata[COEF_W-1:0];
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            active <= '0;
        else if (frame_start)
            active <= shadow;
    end

    p_commit_r8: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> active == $past(shadow));
    p_hold_active_r8: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(active));
    p_unmapped_r9: assert property (@(posedge clk) disable iff (rst)
        (we && addr > ADR_LAST) |=> $stable(shadow));
endmodule

// File: rtl/csc_row.sv
module csc_row
    import csc_pkg::*;
(
    input  logic [NCH-1:0][A_W-1:0]    a,
    input  logic [NCH-1:0][COEF_W-1:0] k,
    input  logic [OFS_W-1:0]           post,
    output pix_t                       y
);
    logic signed [PROD_W-1:0] prod [NCH];
    logic signed [ACC_W-1:0]  acc;
    logic signed [ACC_W-1:0]  shifted;
    logic signed [ACC_W-1:0]  biased;

    always_comb begin
        acc = '0;
        for (int i = 0; i < NCH; i++) begin
            prod[i] = $signed(a[i]) * $signed(k[i]);
            acc     = acc + ACC_W'(prod[i]);
        end
        shifted = round_shift(acc);
        biased  = shifted + ACC_W'($signed(post));
        y       = sat_pix(biased);
    end
endmodule

// File: rtl/csc_pipe.sv
module csc_pipe
    import csc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  csc_cfg_t cfg,
    input  logic     in_valid,
    input  pixel_t   in_pix,
    output logic     out_valid,
    output pixel_t   out_pix
);
    logic                   v1, en1;
    pixel_t                 raw1;
    logic [NCH-1:0][A_W-1:0] a1;
    pixel_t                 conv;
    logic [1:0]             warm;

    always_ff @(posedge clk) begin
        if (rst) begin
            v1   <= 1'b0;
            en1  <= 1'b0;
            raw1 <= '0;
            a1   <= '0;
        end else begin
            v1   <= in_valid;
            en1  <= cfg.en;
            raw1 <= in_pix;
            for (int i = 0; i < NCH; i++)
                a1[i] <= {{(A_W-PIX_W){1'b0}}, in_pix[i]}
                       + {{(A_W-OFS_W){cfg.pre[i][OFS_W-1]}}, cfg.pre[i]};
        end
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_row
        csc_row u_row (
            .a    (a1),
            .k    (cfg.coef[ch]),
            .post (cfg.post[ch]),
            .y    (conv[ch])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= v1;
            out_pix   <= en1 ? conv : raw1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            warm <= '0;
        else if (warm != 2'd2)
            warm <= warm + 2'd1;
    end

    p_valid_delay_r2: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd2) |-> out_valid == $past(in_valid, 2));
    p_bypass_exact_r3: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd2 && !$past(en1)) |-> out_pix == $past(in_pix, 2));
endmodule

// File: rtl/csc_matrix_top.sv
module csc_matrix_top
    import csc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    input  logic              frame_start,
    input  logic              in_valid,
    input  logic [PIX_W-1:0]  in_r,
    input  logic [PIX_W-1:0]  in_g,
    input  logic [PIX_W-1:0]  in_b,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_c0,
    output logic [PIX_W-1:0]  out_c1,
    output logic [PIX_W-1:0]  out_c2
);
    csc_cfg_t cfg_act;
    pixel_t   pix_in, pix_out;

    assign pix_in[0] = in_r;
    assign pix_in[1] = in_g;
    assign pix_in[2] = in_b;

    csc_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .we          (cfg_we),
        .addr        (cfg_addr),
        .wdata       (cfg_wdata),
        .frame_start (frame_start),
        .active      (cfg_act)
    );

    csc_pipe u_pipe (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg_act),
        .in_valid  (in_valid),
        .in_pix    (pix_in),
        .out_valid (out_valid),
        .out_pix   (pix_out)
    );

    assign out_c0 = pix_out[0];
    assign out_c1 = pix_out[1];
    assign out_c2 = pix_out[2];
endmodule

// File: tb/csc_matrix_top_tb_top.sv
module csc_matrix_top_tb_top;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst, cfg_we, frame_start, in_valid;
    logic [3:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic [9:0]  in_r, in_g, in_b;
    logic        out_valid;
    logic [9:0]  out_c0, out_c1, out_c2;

    csc_matrix_top dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .frame_start(frame_start), .in_valid(in_valid),
        .in_r(in_r), .in_g(in_g), .in_b(in_b), .out_valid(out_valid),
        .out_c0(out_c0), .out_c1(out_c1), .out_c2(out_c2)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    int act_c[9], act_pre[3], act_post[3];
    bit act_en;
    int pnd_c[9], pnd_pre[3], pnd_post[3];
    bit pnd_en;

    bit    d1v = 0, d2v = 0;
    int    d1[3], d2[3];
    string d1t = "R2", d2t = "R2";

    function automatic int clip10(int v);
        if (v < 0) return 0;
        if (v > 1023) return 1023;
        return v;
    endfunction

    task automatic model(input int p[3], output int y[3]);
        for (int i = 0; i < 3; i++) begin
            int acc = 0;
            if (!act_en) begin
                y[i] = p[i];
            end else begin
                for (int k = 0; k < 3; k++)
                    acc += act_c[i*3+k] * (p[k] + act_pre[k]);
                y[i] = clip10(((acc + 512) >>> 10) + act_post[i]);
            end
        end
    endtask

    task automatic cyc(input bit v, input int r, input int g, input int b, input string tag);
        int p[3];
        int y[3];
        int o[3];
        @(negedge clk);
        o[0] = int'(out_c0); o[1] = int'(out_c1); o[2] = int'(out_c2);
        checks++;
        if (out_valid !== d2v) begin
            fails++;
            $display("FAIL %s out_valid actual=%0b expected=%0b", d2t, out_valid, d2v);
        end
        if (d2v) begin
            for (int i = 0; i < 3; i++) begin
                checks++;
                if (o[i] != d2[i]) begin
                    fails++;
                    $display("FAIL %s ch%0d actual=%0d expected=%0d", d2t, i, o[i], d2[i]);
                end
            end
        end
        d2v = d1v; d2 = d1; d2t = d1t;
        p[0] = r; p[1] = g; p[2] = b;
        model(p, y);
        d1v = v; d1 = y; d1t = tag;
        in_valid = v; in_r = 10'(r); in_g = 10'(g); in_b = 10'(b);
    endtask

    task automatic flush();
        cyc(0, 0, 0, 0, "R2");
        cyc(0, 0, 0, 0, "R2");
        cyc(0, 0, 0, 0, "R2");
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [31:0] pk13(int hi, int lo);
        return (32'(hi & 'h1fff) << 16) | 32'(lo & 'h1fff);
    endfunction
    function automatic logic [31:0] pk12(int hi, int lo);
        return (32'(hi & 'hfff) << 16) | 32'(lo & 'hfff);
    endfunction

    // R6/R7 layout used to program the pending settings
    task automatic load(input bit en, input int c[9], input int pre[3], input int post[3],
                        input logic [31:0] ctrl_extra);
        flush();
        wr(4'd0, ctrl_extra | 32'(en));
        wr(4'd1, pk12(pre[0], pre[1]));
        wr(4'd2, pk12(0, pre[2]));
        for (int k = 0; k < 4; k++)
            wr(4'(3 + k), pk13(c[2*k], c[2*k+1]));
        wr(4'd7, pk13(c[8], 0));
        wr(4'd8, pk12(post[0], post[1]));
        wr(4'd9, pk12(0, post[2]));
        pnd_en = en; pnd_c = c; pnd_pre = pre; pnd_post = post;
    endtask

    task automatic commit();
        flush();
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
        act_en = pnd_en; act_c = pnd_c; act_pre = pnd_pre; act_post = pnd_post;
    endtask

    task automatic sweep(input int n, input bit gaps, input string tag);
        int cnt = 0;
        for (int ir = 0; ir < n; ir++)
            for (int ig = 0; ig < n; ig++)
                for (int ib = 0; ib < n; ib++) begin
                    bit v = gaps ? (cnt % 3 != 1) : 1'b1;
                    cyc(v, ir*1023/(n-1), ig*1023/(n-1), ib*1023/(n-1), tag);
                    cnt++;
                end
        flush();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; frame_start = 0;
        in_valid = 0; in_r = 0; in_g = 0; in_b = 0;
        act_en = 0; act_c = '{default:0}; act_pre = '{default:0}; act_post = '{default:0};
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state, idle output and pass-through before any commit
        checks++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 out_valid actual=%0b expected=0", out_valid);
        end
        sweep(4, 0, "R1");

        // R4: identity, then R6 with RGB to limited YCbCr (distinct coefficients)
        load(1, '{1024,0,0, 0,1024,0, 0,0,1024}, '{0,0,0}, '{0,0,0}, 32'd0);
        commit();
        sweep(16, 0, "R4");
        load(1, '{186,627,63, -103,-345,448, 448,-407,-41}, '{0,0,0}, '{64,512,512}, 32'd0);
        commit();
        sweep(16, 0, "R6");

        // R8: pending writes ignored until strobe
        load(1, '{-1024,0,0, 0,-512,0, 300,300,300}, '{100,-50,7}, '{1000,900,-5}, 32'd0);
        sweep(4, 0, "R8");
        commit();
        sweep(6, 0, "R8");
        // R8: a write in the strobe cycle waits for the next strobe
        flush();
        @(negedge clk); cfg_we = 1; cfg_addr = 4'd0; cfg_wdata = 32'd0; frame_start = 1;
        @(negedge clk); cfg_we = 0; frame_start = 0;
        sweep(4, 0, "R8");
        pnd_en = 0;
        commit();
        sweep(4, 0, "R8");

        // R5 and R7: extreme coefficients and offsets, both saturation ends
        load(1, '{4095,4095,4095, -4096,-4096,-4096, 1024,-1024,0},
             '{2047,-2048,1000}, '{-2048,2047,-7}, 32'd0);
        commit();
        sweep(16, 0, "R5");
        load(1, '{1024,0,0, 0,1024,0, 0,0,1024}, '{-300,200,-1}, '{5,-600,-1}, 32'd0);
        commit();
        sweep(12, 0, "R7");

        // R4: single-unit coefficients exercise rounding and floor shift
        load(1, '{1,0,0, -1,0,0, 3,-2,0}, '{0,0,0}, '{0,5,1}, 32'd0);
        commit();
        for (int r = 0; r < 1024; r++)
            cyc(1, r, 1023 - r, 0, "R4");
        flush();

        // R3 and R2: enable clear with other control bits set, valid gaps
        load(0, '{186,627,63, -103,-345,448, 448,-407,-41}, '{9,9,9}, '{64,512,512}, 32'hFFFF_FFFE);
        commit();
        sweep(8, 1, "R3");
        load(1, '{186,627,63, -103,-345,448, 448,-407,-41}, '{0,0,0}, '{64,512,512}, 32'd0);
        commit();
        sweep(8, 1, "R2");

        // R9: unmapped addresses leave the settings unchanged
        flush();
        for (int a = 10; a < 16; a++)
            wr(4'(a), 32'hDEAD_BEEF);
        commit();
        sweep(6, 0, "R9");

        done = 1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule